// File: doc/BRIEF.md
# BCD Watchdog Timer with Timeout Steering

The block is a watchdog that counts down a timeout held as four BCD digits, two for whole seconds and two for hundredths of a second, so the timeout ranges from 00.01 s to 99.99 s. A 100 Hz strobe, produced elsewhere from the crystal, moves the count down by one hundredth while the watchdog is enabled. Software sets the timeout through two byte-wide count registers. Writing either register reloads the counter, and that write is also the kick that keeps the timer from expiring.

When the count reaches zero, the block sets a sticky watchdog flag. A steering bit then picks the action. With steering set, the block drives a reset pulse of fixed length, then reloads the counter and starts again. With steering clear, the block raises an interrupt request flag, which drives the shared interrupt line, and reloads the counter at once. A read of the status register returns both flags and clears them.

Top module: `bcd_watchdog`

## Requirements
- R1: Register map, using a 4-bit address and the low eight bits of data. 0xC holds hundredths as two BCD digits (tens in bits 7:4). 0xD holds seconds in the same form. 0xF is control: bit 1 enables the watchdog and bit 0 is steering. 0xE is status: bit 1 is the watchdog flag and bit 0 is the interrupt request flag. Unused bits and any other address read as zero.
- R2: After a synchronous reset, all registers and the counter are zero, and the reset and interrupt outputs are low.
- R3: A write to 0xC or 0xD reloads the counter from both registers, using the newly written byte. This restarts the full timeout.
- R4: While enabled, each tick strobe lowers the counter by one hundredth. A load of S seconds and H hundredths therefore times out on tick number S*100+H after the load, and no earlier.
- R5: A borrow between digits keeps every digit in 0 to 9. For example, 10.00 steps to 09.99 and 01.00 steps to 00.99, so the tick counts in R4 hold across digit boundaries.
- R6: A loaded value of 00.00 never times out, even with enable set and ticks arriving.
- R7: With enable clear, ticks leave the count unchanged. When enable is set again, counting resumes from the held value.
- R8: With steering set, a timeout sets the watchdog flag and drives the reset output high for exactly RST_CYCLES clock cycles (default 16), starting on the edge of the expiring tick. The interrupt is not raised. Ticks during the pulse are ignored, and the counter reloads from the registers when the pulse ends.
- R9: With steering clear, a timeout sets both the watchdog flag and the interrupt flag, the interrupt output goes high, and the counter reloads at once.
- R10: A read of 0xE returns the flags as they are and then clears both of them, which drops the interrupt output.
- R11: The largest timeout, 99.99, expires on tick 9999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle 100 Hz strobe |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (clears status when reading 0xE) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| wd_reset_o | output | 1 | Reset pulse on a steered timeout |
| irq_o | output | 1 | Interrupt request, high while the interrupt flag is set |

## Verification
The bench sweeps loads that sit on digit boundaries (00.01, 00.09, 00.10, 01.00, 10.00, 10.99 and others), up to the full 99.99. It counts the ticks to the interrupt for each load. A borrow that produced a digit above 9, or one that skipped a digit, would make that count wrong. Other tests check that a load of 00.00 never fires, that a rewrite in mid-count restarts the full timeout, and that disabling freezes the count. It also measures the length of the reset pulse while ticks keep arriving. A counter that kept counting during the pulse, or did not reload after it, would give the wrong time to the second pulse. A steering decode that was inverted or missing would raise the wrong output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DIGIT_W = 4;
    localparam int DIGITS  = 4;
    localparam int COUNT_W = DIGIT_W * DIGITS;

    localparam logic [3:0] ADDR_HUND = 4'hC;
    localparam logic [3:0] ADDR_SEC  = 4'hD;
    localparam logic [3:0] ADDR_STAT = 4'hE;
    localparam logic [3:0] ADDR_CTRL = 4'hF;

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef struct packed {
        logic enable;
        logic steer;
    } wd_ctrl_t;

    typedef struct packed {
        logic wd_flag;
        logic irq_flag;
    } wd_stat_t;

    function automatic bcd_t bcd_digit_dec(bcd_t d);
        return (d == '0) ? bcd_t'(9) : d - bcd_t'(1);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic                 re,
    input  logic [3:0]           addr,
    input  logic [7:0]           wdata,
    input  logic                 set_wd,
    input  logic                 set_irq,
    output logic [7:0]           rdata,
    output wd_ctrl_t             ctrl_q,
    output wd_stat_t             stat_q,
    output logic                 count_wr,
    output logic [COUNT_W-1:0]   reload_val
);

    logic [7:0] hund_q;
    logic [7:0] sec_q;
    logic       wr_hund;
    logic       wr_sec;
    logic       rd_stat;

    assign wr_hund  = we && (addr == ADDR_HUND);
    assign wr_sec   = we && (addr == ADDR_SEC);
    assign rd_stat  = re && (addr == ADDR_STAT);
    assign count_wr = wr_hund || wr_sec;

    assign reload_val = {(wr_sec ? wdata : sec_q), (wr_hund ? wdata : hund_q)};

    always_ff @(posedge clk) begin
        if (rst) begin
            hund_q <= '0;
            sec_q  <= '0;
            ctrl_q <= '0;
        end else if (we) begin
            if (addr == ADDR_HUND) hund_q <= wdata;
            if (addr == ADDR_SEC)  sec_q  <= wdata;
            if (addr == ADDR_CTRL) ctrl_q <= wd_ctrl_t'(wdata[1:0]);
        end
    end

    // Setting a flag takes priority over a clearing read in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            if (rd_stat) stat_q <= '0;
            if (set_wd)  stat_q.wd_flag  <= 1'b1;
            if (set_irq) stat_q.irq_flag <= 1'b1;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_HUND: rdata = hund_q;
            ADDR_SEC:  rdata = sec_q;
            ADDR_STAT: rdata = {6'b0, stat_q};
            ADDR_CTRL: rdata = {6'b0, ctrl_q};
            default:   rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/wdt_bcd_counter.sv
module wdt_bcd_counter
    import wdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [COUNT_W-1:0] load_val,
    input  logic               dec,
    output logic [COUNT_W-1:0] cnt_q,
    output logic               is_zero,
    output logic               is_one
);

    logic [COUNT_W-1:0] dec_val;
    logic [DIGITS-1:0]  borrow;

    assign borrow[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        assign dec_val[g*DIGIT_W +: DIGIT_W] = borrow[g]
            ? bcd_digit_dec(cnt_q[g*DIGIT_W +: DIGIT_W])
            : cnt_q[g*DIGIT_W +: DIGIT_W];
        if (g < DIGITS - 1) begin : g_chain
            assign borrow[g+1] = borrow[g] && (cnt_q[g*DIGIT_W +: DIGIT_W] == '0);
        end
    end

    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == COUNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= dec_val;
    end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left_q;

    assign active = (left_q != '0);
    assign done   = (left_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst)         left_q <= '0;
        else if (start)  left_q <= CW'(CYCLES);
        else if (active) left_q <= left_q - CW'(1);
    end

endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog
    import wdt_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       bus_we,
    input  logic       bus_re,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wd_reset_o,
    output logic       irq_o
);

    wd_ctrl_t           ctrl_q;
    wd_stat_t           stat_q;
    logic               count_wr;
    logic [COUNT_W-1:0] reload_val;
    logic [COUNT_W-1:0] cnt_q;
    logic               cnt_zero;
    logic               cnt_one;
    logic               pulse_active;
    logic               pulse_done;
    logic               cnt_dec;
    logic               expire;
    logic               cnt_load;

    assign cnt_dec  = tick_i && ctrl_q.enable && !cnt_zero && !pulse_active;
    assign expire   = cnt_dec && cnt_one;
    assign cnt_load = count_wr || (expire && !ctrl_q.steer) || pulse_done;

    wdt_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (bus_we),
        .re         (bus_re),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .set_wd     (expire),
        .set_irq    (expire && !ctrl_q.steer),
        .rdata      (bus_rdata),
        .ctrl_q     (ctrl_q),
        .stat_q     (stat_q),
        .count_wr   (count_wr),
        .reload_val (reload_val)
    );

    wdt_bcd_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (reload_val),
        .dec      (cnt_dec),
        .cnt_q    (cnt_q),
        .is_zero  (cnt_zero),
        .is_one   (cnt_one)
    );

    wdt_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .start  (expire && ctrl_q.steer),
        .active (pulse_active),
        .done   (pulse_done)
    );

    assign wd_reset_o = pulse_active;
    assign irq_o      = stat_q.irq_flag;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic               load,
    input logic               enable,
    input logic [COUNT_W-1:0] cnt,
    input logic               wd_reset,
    input logic               irq,
    input logic               wd_flag
);

    localparam int RW = $clog2(RST_CYCLES + 2) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)           run_q <= '0;
        else if (wd_reset) run_q <= run_q + RW'(1);
        else               run_q <= '0;
    end

    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_reset) |-> (run_q == RW'(RST_CYCLES)));

    assert_irq_with_flag_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (wd_flag && !wd_reset));

    assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!enable && !load) |=> $stable(cnt));

    assert_zero_stays_R6: assert property (@(posedge clk) disable iff (rst)
        ((cnt == '0) && !load) |=> (cnt == '0));

    assert_tick_paced_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt));

endmodule

bind bcd_watchdog wdt_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_i),
    .load     (cnt_load),
    .enable   (ctrl_q.enable),
    .cnt      (cnt_q),
    .wd_reset (wd_reset_o),
    .irq      (irq_o),
    .wd_flag  (stat_q.wd_flag)
);

// File: tb/tb_bcd_watchdog.sv
module tb_bcd_watchdog;

    localparam int RST_CYCLES = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wd_reset_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    bcd_watchdog #(.RST_CYCLES(RST_CYCLES)) dut (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .wd_reset_o (wd_reset_o),
        .irq_o      (irq_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) + (v % 10));
    endfunction

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic one_tick();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    // Loads S.H, applies up to limit ticks, returns the first tick that raised irq.
    task automatic measure(input int s, input int h, input int limit, output int fired);
        logic [7:0] d;
        bus_write(4'hC, to_bcd(h));
        bus_write(4'hD, to_bcd(s));
        fired = -1;
        for (int i = 1; i <= limit; i++) begin
            one_tick();
            if (irq_o && fired < 0) fired = i;
        end
        bus_read(4'hE, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int fired;
        int width;
        int sv[3];
        int hv[5];
        sv = '{0, 1, 10};
        hv = '{0, 1, 9, 10, 99};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        check("R2 outputs", {30'b0, wd_reset_o, irq_o}, 0);
        bus_read(4'hC, d); check("R2 hund", d, 0);
        bus_read(4'hD, d); check("R2 sec", d, 0);
        bus_read(4'hE, d); check("R2 stat", d, 0);
        bus_read(4'hF, d); check("R2 ctrl", d, 0);

        // R1 register map
        bus_write(4'hC, 8'h47);
        bus_write(4'hD, 8'h82);
        bus_write(4'hF, 8'hFF);
        bus_read(4'hC, d); check("R1 hund readback", d, 'h47);
        bus_read(4'hD, d); check("R1 sec readback", d, 'h82);
        bus_read(4'hF, d); check("R1 ctrl readback", d, 'h03);
        bus_read(4'h3, d); check("R1 unmapped", d, 0);

        // Interrupt mode, enabled
        bus_write(4'hF, 8'h02);

        // R4 R5 sweep across digit boundaries
        foreach (sv[i]) begin
            foreach (hv[j]) begin
                int n;
                n = sv[i] * 100 + hv[j];
                measure(sv[i], hv[j], (n == 0) ? 6 : n + 2, fired);
                if (n == 0) check("R6 zero load never fires", fired, -1);
                else        check("R4 R5 ticks to timeout", fired, n);
            end
        end

        // R11 maximum timeout
        measure(99, 99, 10001, fired);
        check("R11 99.99 ticks", fired, 9999);

        // R9 and R10: flags, irq output and read-to-clear
        bus_write(4'hC, 8'h02);
        bus_write(4'hD, 8'h00);
        one_tick();
        check("R9 no early irq", irq_o, 0);
        one_tick();
        check("R9 irq raised", irq_o, 1);
        check("R9 no reset pulse", wd_reset_o, 0);
        bus_read(4'hE, d); check("R10 status before clear", d, 'h03);
        check("R10 irq dropped", irq_o, 0);
        bus_read(4'hE, d); check("R10 status after clear", d, 0);
        // reloaded at once: two more ticks fire again
        one_tick();
        one_tick();
        check("R9 immediate reload", irq_o, 1);
        bus_read(4'hE, d);

        // R3 kick restarts the full timeout
        bus_write(4'hC, 8'h05);
        repeat (4) one_tick();
        bus_write(4'hC, 8'h05);
        repeat (4) one_tick();
        check("R3 kick delays timeout", irq_o, 0);
        one_tick();
        check("R3 timeout after kick", irq_o, 1);
        bus_read(4'hE, d);

        // R7 disable holds the count
        bus_write(4'hC, 8'h05);
        repeat (2) one_tick();
        bus_write(4'hF, 8'h00);
        repeat (10) one_tick();
        check("R7 no timeout when disabled", irq_o, 0);
        bus_write(4'hF, 8'h02);
        repeat (2) one_tick();
        check("R7 resumes from held count", irq_o, 0);
        one_tick();
        check("R7 timeout after resume", irq_o, 1);
        bus_read(4'hE, d);

        // R8 steered reset pulse
        bus_write(4'hF, 8'h03);
        bus_write(4'hC, 8'h03);
        repeat (2) one_tick();
        check("R8 no early pulse", wd_reset_o, 0);
        one_tick();
        check("R8 pulse starts", wd_reset_o, 1);
        width = 1;
        tick_i = 1'b1;
        while (wd_reset_o && width < 100) begin
            @(negedge clk);
            if (wd_reset_o) width++;
        end
        tick_i = 1'b0;
        check("R8 pulse width", width, RST_CYCLES);
        check("R8 no irq", irq_o, 0);
        bus_read(4'hE, d); check("R8 watchdog flag only", d, 'h02);
        repeat (2) one_tick();
        check("R8 reloaded, no early pulse", wd_reset_o, 0);
        one_tick();
        check("R8 second pulse after reload", wd_reset_o, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule